// File: doc/BRIEF.md
# Strided Two-Window Sample Gatherer

This block rebuilds a readout window in a shared single-port RAM from a capture that is already stored there. On a start pulse it copies two decimated subsets out of the capture region into a destination area. The first subset begins at the capture base and advances by `step1`. The second subset begins at the capture base plus five times `shift` times `step1`, and advances by `step2`. After the two subsets it writes a three-byte end marker. It then appends a tail that copies a fixed source span, which may overlap bytes written earlier in the same run.

The block drives the RAM address, write data and write enable. The RAM returns read data one cycle after the address. Every copied byte costs one read cycle and then one write cycle. Source addresses come from running adders and wrap modulo 2^ADDR_W. A one-cycle `done` marks the end of a run. The whole window is rebuilt on every accepted start, and a start pulse that arrives during a run is dropped.

Top module: `subset_gather`

## Requirements
- R1: During a run, writes go only to DST_BASE .. DST_BASE+2*SUB_LEN+2+TAIL_LEN, modulo 2^ADDR_W. No write occurs outside a run, and every other RAM location keeps its value.
- R2: For k in 0..SUB_LEN-1, location DST_BASE+k receives the byte at SRC_BASE+k*step1.
- R3: For k in 0..SUB_LEN-1, location DST_BASE+SUB_LEN+k receives the byte at SRC_BASE+5*shift*step1+k*step2.
- R4: Locations DST_BASE+2*SUB_LEN, +1 and +2 receive 8'h01, 8'hFE and 8'h80, in that order.
- R5: For k in 0..TAIL_LEN-1, location DST_BASE+2*SUB_LEN+3+k receives the byte that TAIL_SRC+k holds at the moment it is read. Bytes written earlier in the same run are therefore seen.
- R6: Each copied byte takes one read cycle followed by one write cycle, and the write carries the data just read. Each marker byte takes one write cycle. Computing the offset takes shift+1 cycles. As a result, `done` is high in cycle shift+4*SUB_LEN+2*TAIL_LEN+4 after the clock edge that samples `start`.
- R7: `done` is high for exactly one cycle, in the cycle right after the last tail byte is written.
- R8: A `start` pulse while a run is in progress, including the cycle in which `done` is high, is ignored. It does not change the results, the timing or the writes that follow.
- R9: All source address arithmetic, including the subset-two offset, wraps modulo 2^ADDR_W.
- R10: While `rst` is high, `done` and `ramWe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to rebuild the window |
| step1 | input | STEP_W | Stride of subset one, sampled at start |
| step2 | input | STEP_W | Stride of subset two, sampled at start |
| shift | input | STEP_W | Offset multiplier for subset two, sampled at start |
| ramAddr | output | ADDR_W | RAM address |
| ramWe | output | 1 | RAM write enable |
| ramWdata | output | 8 | RAM write data |
| ramRdata | input | 8 | RAM read data, valid one cycle after the address |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the block with a 10-bit address space, 16-byte subsets, an 8-byte tail, and a tail source placed inside the span that subset two writes. With this setup, 8-bit strides and offsets wrap the source pointer into the destination window, and the tail must see data written earlier in the same run. It also lets a reference image of the whole 1024-byte RAM be compared after every run. The stride and offset sets include a zero stride, a zero shift and the maximum shift.

// File: rtl/sg_pkg.sv
package sg_pkg;

  localparam logic [7:0] MARK0 = 8'h01;
  localparam logic [7:0] MARK1 = 8'hFE;
  localparam logic [7:0] MARK2 = 8'h80;

  typedef enum logic [2:0] {
    SRC_HOLD,
    SRC_ADV1,
    SRC_ADV2,
    SRC_ADV_ONE,
    SRC_LOAD_SUB2,
    SRC_LOAD_TAIL
  } srcOpT;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OFFS,
    PH_SUB1,
    PH_SUB2,
    PH_MARK,
    PH_TAIL,
    PH_DONE
  } phaseT;

  typedef struct packed {
    logic       loadCfg;
    logic       offStep;
    srcOpT      srcOp;
    logic       dstInc;
    logic       useSrcAddr;
    logic       wrCopy;
    logic       wrMark;
    logic [1:0] markIdx;
  } ctlT;

endpackage

// File: rtl/sg_ctrl.sv
module sg_ctrl
  import sg_pkg::*;
#(
  parameter int SUB_LEN  = 500,
  parameter int TAIL_LEN = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic offDone,
  output ctlT  ctl,
  output logic done
);

  localparam int MAX_LEN = (SUB_LEN > TAIL_LEN) ? SUB_LEN : TAIL_LEN;
  localparam int CNT_W   = ($clog2(MAX_LEN) > 2) ? $clog2(MAX_LEN) : 2;
  localparam logic [CNT_W-1:0] SUB_LAST  = CNT_W'(SUB_LEN - 1);
  localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_LEN - 1);
  localparam logic [CNT_W-1:0] MARK_LAST = CNT_W'(2);

  phaseT            phase, phaseNext;
  logic             wrSlot, wrSlotNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [CNT_W-1:0] lastIdx;

  always_comb begin
    case (phase)
      PH_SUB1, PH_SUB2: lastIdx = SUB_LAST;
      default:          lastIdx = TAIL_LAST;
    endcase
  end

  always_comb begin
    ctl        = '0;
    phaseNext  = phase;
    wrSlotNext = wrSlot;
    cntNext    = cnt;
    case (phase)
      PH_IDLE: begin
        if (start) begin
          ctl.loadCfg = 1'b1;
          phaseNext   = PH_OFFS;
        end
      end
      PH_OFFS: begin
        if (offDone) begin
          phaseNext  = PH_SUB1;
          wrSlotNext = 1'b0;
          cntNext    = '0;
        end else begin
          ctl.offStep = 1'b1;
        end
      end
      PH_SUB1, PH_SUB2, PH_TAIL: begin
        if (!wrSlot) begin
          ctl.useSrcAddr = 1'b1;
          wrSlotNext     = 1'b1;
        end else begin
          ctl.wrCopy = 1'b1;
          ctl.dstInc = 1'b1;
          wrSlotNext = 1'b0;
          if (cnt == lastIdx) begin
            cntNext = '0;
            case (phase)
              PH_SUB1: begin
                phaseNext = PH_SUB2;
                ctl.srcOp = SRC_LOAD_SUB2;
              end
              PH_SUB2: phaseNext = PH_MARK;
              default: phaseNext = PH_DONE;
            endcase
          end else begin
            cntNext = cnt + 1'b1;
            case (phase)
              PH_SUB1: ctl.srcOp = SRC_ADV1;
              PH_SUB2: ctl.srcOp = SRC_ADV2;
              default: ctl.srcOp = SRC_ADV_ONE;
            endcase
          end
        end
      end
      PH_MARK: begin
        ctl.wrMark  = 1'b1;
        ctl.markIdx = cnt[1:0];
        ctl.dstInc  = 1'b1;
        if (cnt == MARK_LAST) begin
          cntNext    = '0;
          wrSlotNext = 1'b0;
          phaseNext  = PH_TAIL;
          ctl.srcOp  = SRC_LOAD_TAIL;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      PH_DONE: phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      wrSlot <= 1'b0;
      cnt    <= '0;
    end else begin
      phase  <= phaseNext;
      wrSlot <= wrSlotNext;
      cnt    <= cntNext;
    end
  end

  assign done = (phase == PH_DONE);

endmodule

// File: rtl/sg_datapath.sv
module sg_datapath
  import sg_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int STEP_W   = 8,
  parameter int SRC_BASE = 'h6000,
  parameter int DST_BASE = 'h4000,
  parameter int TAIL_SRC = 'h4320
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlT               ctl,
  input  logic [STEP_W-1:0] step1,
  input  logic [STEP_W-1:0] step2,
  input  logic [STEP_W-1:0] shift,
  input  logic [7:0]        ramRdata,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]        ramWdata,
  output logic              ramWe,
  output logic              offDone
);

  localparam logic [ADDR_W-1:0] SRC_A  = ADDR_W'(SRC_BASE);
  localparam logic [ADDR_W-1:0] DST_A  = ADDR_W'(DST_BASE);
  localparam logic [ADDR_W-1:0] TAIL_A = ADDR_W'(TAIL_SRC);

  logic [STEP_W-1:0] s1Reg, s2Reg, shLeft;
  logic [ADDR_W-1:0] offAcc, srcPtr, dstPtr;
  logic [ADDR_W-1:0] s1Ext, s2Ext, s1Times5;
  logic [7:0]        markByte;

  assign s1Ext    = ADDR_W'(s1Reg);
  assign s2Ext    = ADDR_W'(s2Reg);
  assign s1Times5 = (s1Ext << 2) + s1Ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Reg  <= '0;
      s2Reg  <= '0;
      shLeft <= '0;
      offAcc <= '0;
      srcPtr <= SRC_A;
      dstPtr <= DST_A;
    end else begin
      if (ctl.loadCfg) begin
        s1Reg  <= step1;
        s2Reg  <= step2;
        shLeft <= shift;
        offAcc <= '0;
        dstPtr <= DST_A;
      end
      if (ctl.offStep) begin
        offAcc <= offAcc + s1Times5;
        shLeft <= shLeft - 1'b1;
      end
      if (ctl.loadCfg) begin
        srcPtr <= SRC_A;
      end else begin
        case (ctl.srcOp)
          SRC_ADV1:      srcPtr <= srcPtr + s1Ext;
          SRC_ADV2:      srcPtr <= srcPtr + s2Ext;
          SRC_ADV_ONE:   srcPtr <= srcPtr + 1'b1;
          SRC_LOAD_SUB2: srcPtr <= SRC_A + offAcc;
          SRC_LOAD_TAIL: srcPtr <= TAIL_A;
          default:       srcPtr <= srcPtr;
        endcase
      end
      if (ctl.dstInc) begin
        dstPtr <= dstPtr + 1'b1;
      end
    end
  end

  always_comb begin
    case (ctl.markIdx)
      2'd0:    markByte = MARK0;
      2'd1:    markByte = MARK1;
      default: markByte = MARK2;
    endcase
  end

  assign offDone  = (shLeft == '0);
  assign ramAddr  = ctl.useSrcAddr ? srcPtr : dstPtr;
  assign ramWe    = ctl.wrCopy | ctl.wrMark;
  assign ramWdata = ctl.wrMark ? markByte : ramRdata;

endmodule

// File: rtl/subset_gather.sv
module subset_gather
  import sg_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int STEP_W   = 8,
  parameter int SUB_LEN  = 500,
  parameter int TAIL_LEN = 100,
  parameter int SRC_BASE = 'h6000,
  parameter int DST_BASE = 'h4000,
  parameter int TAIL_SRC = 'h4320
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [STEP_W-1:0] step1,
  input  logic [STEP_W-1:0] step2,
  input  logic [STEP_W-1:0] shift,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWe,
  output logic [7:0]        ramWdata,
  input  logic [7:0]        ramRdata,
  output logic              done
);

  ctlT  ctl;
  logic offDone;

  sg_ctrl #(
    .SUB_LEN (SUB_LEN),
    .TAIL_LEN(TAIL_LEN)
  ) uCtrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .offDone(offDone),
    .ctl    (ctl),
    .done   (done)
  );

  sg_datapath #(
    .ADDR_W  (ADDR_W),
    .STEP_W  (STEP_W),
    .SRC_BASE(SRC_BASE),
    .DST_BASE(DST_BASE),
    .TAIL_SRC(TAIL_SRC)
  ) uPath (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .step1   (step1),
    .step2   (step2),
    .shift   (shift),
    .ramRdata(ramRdata),
    .ramAddr (ramAddr),
    .ramWdata(ramWdata),
    .ramWe   (ramWe),
    .offDone (offDone)
  );

endmodule

// File: rtl/subset_gather_chk.sv
module subset_gather_chk #(
  parameter int ADDR_W   = 15,
  parameter int STEP_W   = 8,
  parameter int SUB_LEN  = 500,
  parameter int TAIL_LEN = 100,
  parameter int SRC_BASE = 'h6000,
  parameter int DST_BASE = 'h4000,
  parameter int TAIL_SRC = 'h4320
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [STEP_W-1:0] step1,
  input logic [STEP_W-1:0] step2,
  input logic [STEP_W-1:0] shift,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              ramWe,
  input logic [7:0]        ramWdata,
  input logic [7:0]        ramRdata,
  input logic              done
);

  localparam int TOTAL = 2 * SUB_LEN + 3 + TAIL_LEN;
  localparam logic [ADDR_W-1:0] DST_A  = ADDR_W'(DST_BASE);
  localparam logic [ADDR_W-1:0] MARK_O = ADDR_W'(2 * SUB_LEN);
  localparam logic [ADDR_W-1:0] LAST_O = ADDR_W'(TOTAL - 1);

  logic              runFlag;
  logic [ADDR_W-1:0] winOff;
  logic              inMark;

  assign winOff = ramAddr - DST_A;
  assign inMark = (winOff >= MARK_O) && (winOff < MARK_O + ADDR_W'(3));

  always_ff @(posedge clk) begin
    if (rst)                  runFlag <= 1'b0;
    else if (done)            runFlag <= 1'b0;
    else if (start)           runFlag <= 1'b1;
  end

  AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    ramWe |-> (int'(winOff) < TOTAL)); // R1
  AST_WRITE_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    ramWe |-> runFlag); // R1
  AST_COPY_CARRIES_READ: assert property (@(posedge clk) disable iff (rst)
    (ramWe && !inMark) |-> (ramWdata == ramRdata)); // R6
  AST_MARK_FIRST: assert property (@(posedge clk) disable iff (rst)
    (ramWe && winOff == MARK_O) |-> (ramWdata == 8'h01)); // R4
  AST_MARK_SECOND: assert property (@(posedge clk) disable iff (rst)
    (ramWe && winOff == MARK_O + ADDR_W'(1)) |-> (ramWdata == 8'hFE)); // R4
  AST_MARK_THIRD: assert property (@(posedge clk) disable iff (rst)
    (ramWe && winOff == MARK_O + ADDR_W'(2)) |-> (ramWdata == 8'h80)); // R4
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(ramWe) && $past(winOff) == LAST_O)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_NO_WRITE_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !ramWe); // R7

endmodule

bind subset_gather subset_gather_chk #(
  .ADDR_W  (ADDR_W),
  .STEP_W  (STEP_W),
  .SUB_LEN (SUB_LEN),
  .TAIL_LEN(TAIL_LEN),
  .SRC_BASE(SRC_BASE),
  .DST_BASE(DST_BASE),
  .TAIL_SRC(TAIL_SRC)
) uChk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .step1   (step1),
  .step2   (step2),
  .shift   (shift),
  .ramAddr (ramAddr),
  .ramWe   (ramWe),
  .ramWdata(ramWdata),
  .ramRdata(ramRdata),
  .done    (done)
);

// File: tb/sim_subset_gather.sv
`timescale 1ns/1ps
module sim_subset_gather;

  localparam int AW    = 10;
  localparam int MSZ   = 1 << AW;
  localparam int L     = 16;
  localparam int T     = 8;
  localparam int SRC   = 'h200;
  localparam int DST   = 'h100;
  localparam int TSRC  = 'h114;
  localparam int TOTAL = 2 * L + 3 + T;

  typedef struct packed {
    logic [7:0] s1;
    logic [7:0] s2;
    logic [7:0] sh;
  } vecT;

  localparam int NV = 6;
  localparam vecT VECS [NV] = '{
    '{8'd1,   8'd1,   8'd0},
    '{8'd3,   8'd2,   8'd1},
    '{8'd100, 8'd255, 8'd9},
    '{8'd0,   8'd0,   8'd5},
    '{8'd17,  8'd1,   8'd255},
    '{8'd5,   8'd9,   8'd2}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [7:0]    step1 = '0, step2 = '0, shift = '0;
  logic [AW-1:0] ramAddr;
  logic          ramWe;
  logic [7:0]    ramWdata;
  logic [7:0]    ramRdata;
  logic          done;

  logic          tbWe = 1'b0;
  logic [AW-1:0] tbAddr = '0;
  logic [7:0]    tbData = '0;
  logic [7:0]    mem  [MSZ];
  logic [7:0]    refm [MSZ];

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  subset_gather #(
    .ADDR_W(AW), .STEP_W(8), .SUB_LEN(L), .TAIL_LEN(T),
    .SRC_BASE(SRC), .DST_BASE(DST), .TAIL_SRC(TSRC)
  ) u0 (
    .clk(clk), .rst(rst), .start(start),
    .step1(step1), .step2(step2), .shift(shift),
    .ramAddr(ramAddr), .ramWe(ramWe), .ramWdata(ramWdata),
    .ramRdata(ramRdata), .done(done)
  );

  always_ff @(posedge clk) begin
    if (tbWe)       mem[tbAddr]  <= tbData;
    else if (ramWe) mem[ramAddr] <= ramWdata;
    ramRdata <= mem[ramAddr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic applyRef(input int s1, input int s2, input int sh);
    int src;
    src = SRC;
    for (int k = 0; k < L; k++) begin
      refm[DST + k] = refm[src];
      src = (src + s1) % MSZ;
    end
    src = (SRC + 5 * sh * s1) % MSZ;
    for (int k = 0; k < L; k++) begin
      refm[DST + L + k] = refm[src];
      src = (src + s2) % MSZ;
    end
    refm[DST + 2 * L]     = 8'h01;
    refm[DST + 2 * L + 1] = 8'hFE;
    refm[DST + 2 * L + 2] = 8'h80;
    for (int k = 0; k < T; k++)
      refm[DST + 2 * L + 3 + k] = refm[TSRC + k];
  endtask

  task automatic checkRange(input int lo, input int n, input string req);
    int bad = 0; int act = 0; int exp = 0;
    for (int a = lo; a < lo + n; a++) begin
      if (mem[a] !== refm[a]) begin
        if (bad == 0) begin act = int'(mem[a]); exp = int'(refm[a]); end
        bad++;
      end
    end
    chk(bad == 0, req, act, exp);
  endtask

  task automatic checkOutside(input string req);
    int bad = 0; int act = 0; int exp = 0;
    for (int a = 0; a < MSZ; a++) begin
      if ((a < DST || a >= DST + TOTAL) && mem[a] !== refm[a]) begin
        if (bad == 0) begin act = int'(mem[a]); exp = int'(refm[a]); end
        bad++;
      end
    end
    chk(bad == 0, req, act, exp);
  endtask

  task automatic runVec(input vecT v, input bit pokeBusy, input string pre);
    int cyc;
    bit quiet;
    step1 = v.s1; step2 = v.s2; shift = v.sh;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 4000) begin
      if (pokeBusy && cyc == 20) begin
        start = 1'b1; step1 = v.s1 + 8'd1; shift = 8'd3;
      end else begin
        start = 1'b0; step1 = v.s1; shift = v.sh;
      end
      @(posedge clk); #1;
      cyc++;
    end
    start = 1'b0;
    if (!done) begin
      chk(1'b0, {pre, " watchdog"}, cyc, 0);
      return;
    end
    // R6: cycle budget from the start edge to done
    chk(cyc == int'(v.sh) + 4 * L + 2 * T + 4, {pre, " R6 latency"}, cyc,
        int'(v.sh) + 4 * L + 2 * T + 4);
    // R8: a start in the done cycle is dropped
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk(done == 1'b0, {pre, " R7 single done"}, int'(done), 0);
    quiet = 1'b1;
    repeat (6) begin
      if (ramWe || done) quiet = 1'b0;
      @(posedge clk); #1;
    end
    chk(quiet, {pre, " R8 no run after start in done cycle"}, int'(!quiet), 0);
    applyRef(int'(v.s1), int'(v.s2), int'(v.sh));
    checkRange(DST, L, {pre, " R2 subset one"});
    checkRange(DST + L, L, {pre, " R3 subset two"});
    checkRange(DST + 2 * L, 3, {pre, " R4 marker"});
    checkRange(DST + 2 * L + 3, T, {pre, " R5 tail"});
    checkOutside({pre, " R1 untouched outside window"});
  endtask

  initial begin
    #(5ns * 150000);
    chk(1'b0, "watchdog global", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    for (int i = 0; i < MSZ; i++) begin
      tbAddr = AW'(i);
      tbData = 8'((i * 37 + 11) ^ (i >> 2));
      refm[i] = 8'((i * 37 + 11) ^ (i >> 2));
      tbWe = 1'b1;
      @(posedge clk); #1;
    end
    tbWe = 1'b0;
    // R10: outputs quiet in reset
    chk(done == 1'b0, "R10 done in reset", int'(done), 0);
    chk(ramWe == 1'b0, "R10 write enable in reset", int'(ramWe), 0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(posedge clk); #1;
    chk(ramWe == 1'b0 && done == 1'b0, "R10 idle after reset", int'(ramWe), 0);

    for (int i = 0; i < NV; i++)
      runVec(VECS[i], 1'b0, "table");

    // R9: strides and offset wrap around the address space
    runVec('{s1: 8'd255, s2: 8'd7, sh: 8'd200}, 1'b0, "R9 wrap");
    // R8: start pulse in the middle of a run
    runVec('{s1: 8'd6, s2: 8'd3, sh: 8'd4}, 1'b1, "R8 busy start");
    // R3: zero shift puts subset two at the source base
    runVec('{s1: 8'd40, s2: 8'd2, sh: 8'd0}, 1'b0, "R3 zero shift");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule